// File: doc/BRIEF.md
# Serial Flash Address Width and Composition Controller

This block lives on the device side of a serial NOR flash, behind the serial shifter. For every command it decides how many address bytes follow the opcode. It then collects those bytes and forms the 32-bit internal array address. Three addressing schemes exist side by side:

- a volatile wide-address mode flag, set and cleared by dedicated opcodes;
- a volatile extension register whose live bit becomes address bit 24 when only three address bytes are sent;
- a fixed group of opcodes that always carry four address bytes, whatever the mode flag says.

The flag and the extension register follow different write-enable rules. Setting or clearing the flag needs no write enable. Writing the extension register is accepted only while the write-enable latch is set, and a successful write asks the latch to clear.

The shifter pulses `op_vld_i` with the decoded opcode. One cycle later it reads the expected address byte count, so it knows when the address phase ends. It then presents each received byte with `sbyte_vld_i`. A new opcode strobe always abandons any command still in progress.

The control sequencer has three states:

- `ST_IDLE`: no command is in progress.
- `ST_ADDR`: address bytes are being collected.
- `ST_EARDATA`: the controller waits for the data byte of an accepted extension-register write.

Its transitions are:

- Any state goes to `ST_ADDR` on a strobe of an address-carrying opcode.
- Any state goes to `ST_EARDATA` on a strobe of the register-write opcode while the latch is set.
- Any state goes to `ST_IDLE` on any other strobe, or on software reset.
- `ST_ADDR` returns to `ST_IDLE` when the final address byte arrives.
- `ST_EARDATA` returns to `ST_IDLE` when the data byte arrives.

Top module: `flash_addr_mode_ctrl`

## Requirements
- R1: Opcode B7h sets the wide-address mode and opcode E9h clears it, whatever the value of `wel_i`.
- R2: Hardware reset (`rst_n` low) and software reset (`sw_rst_i` high at a clock edge) both return the block to narrow (3-byte) addressing, clear the extension register and abandon any command.
- R3: `cfg_o` bit 5 reads 1 in wide-address mode and 0 in narrow mode; every other `cfg_o` bit reads 0.
- R4: In narrow mode, a legacy address opcode produces `addr_o = {7'b0, ext_bit, b0, b1, b2}`, where b0 is the first address byte received.
- R5: `ear_o` returns the extension register: bit 0 is the live extension bit and bits 7:1 always read 0. Opcode C8h (read-back) expects 0 address bytes.
- R6: Opcodes 13h, 0Ch, 3Ch, BCh, 6Ch, ECh, 12h, 3Eh, 21h, DCh and 5Ch always expect 4 address bytes, in either mode.
- R7: The legacy address opcodes 03h, 0Bh, 3Bh, BBh, 6Bh, EBh, 02h, 38h, 20h, 52h and D8h expect 3 bytes in narrow mode and 4 in wide mode. Every other opcode expects 0.
- R8: Every 4-byte command produces `addr_o = {b0, b1, b2, b3}`, independent of the extension register.
- R9: Opcode C5h strobed while `wel_i` is 0 is dropped. Its following data byte leaves `ear_o` unchanged, and `wel_clr_o` stays low.
- R10: Opcode C5h strobed while `wel_i` is 1 loads bit 0 of the next received byte into the extension bit. `wel_clr_o` pulses for one cycle together with the update.
- R11: `addr_bytes_vld_o` pulses, and `addr_bytes_o` holds the count, in the cycle after the opcode strobe. `addr_vld_o` pulses with the composed `addr_o` in the cycle after the final address byte.
- R12: A strobe that arrives while address bytes are still being collected abandons the earlier command without producing an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst_i | input | 1 | Synchronous software reset |
| op_vld_i | input | 1 | Opcode strobe from the shifter |
| op_code_i | input | 8 | Decoded opcode |
| wel_i | input | 1 | Write-enable latch status |
| sbyte_vld_i | input | 1 | A received byte is present |
| sbyte_i | input | BYTE_W | Received address or data byte |
| addr_bytes_o | output | CNT_W | Expected address byte count |
| addr_bytes_vld_o | output | 1 | Count valid pulse |
| addr_o | output | ADDR_W | Composed internal address |
| addr_vld_o | output | 1 | Address valid pulse |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |
| cfg_o | output | 8 | Configuration view; bit 5 is the wide-address flag |
| ear_o | output | 8 | Extension register read-back |

## Verification
Every result is due exactly one clock after the stimulus that causes it:

- the byte count follows the opcode strobe by one cycle;
- the address follows the final address byte by one cycle;
- the mode flag, the extension bit and the latch-clear pulse change one cycle after their opcode or data byte.

The bench drives each stimulus on a falling edge, holds it through one rising edge, and samples on the next falling edge. Every check therefore lands in the single cycle in which a pulse output is high. Checks for dropped writes and reserved bits read `ear_o` and `cfg_o`, and repeat a narrow-mode read to confirm that address bit 24 is unchanged.

// File: rtl/flash_am_pkg.sv
package flash_am_pkg;

    localparam int OP_W = 8;

    typedef enum logic [2:0] {
        OPC_NONE,
        OPC_LEGACY,
        OPC_WIDE,
        OPC_ENTER4B,
        OPC_EXIT4B,
        OPC_EARWR,
        OPC_EARRD
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_EARDATA
    } fsm_state_e;

endpackage

// File: rtl/fam_op_decoder.sv
module fam_op_decoder
    import flash_am_pkg::*;
(
    input  logic [OP_W-1:0] op_code_i,
    output op_class_e       op_cls_o
);
    always_comb begin
        case (op_code_i)
            8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC,
            8'h12, 8'h3E, 8'h21, 8'hDC, 8'h5C:          op_cls_o = OPC_WIDE;
            8'h03, 8'h0B, 8'h3B, 8'hBB, 8'h6B, 8'hEB,
            8'h02, 8'h38, 8'h20, 8'h52, 8'hD8:          op_cls_o = OPC_LEGACY;
            8'hB7:                                      op_cls_o = OPC_ENTER4B;
            8'hE9:                                      op_cls_o = OPC_EXIT4B;
            8'hC5:                                      op_cls_o = OPC_EARWR;
            8'hC8:                                      op_cls_o = OPC_EARRD;
            default:                                    op_cls_o = OPC_NONE;
        endcase
    end
endmodule

// File: rtl/fam_mode_regs.sv
module fam_mode_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst_i,
    input  logic enter_i,
    input  logic exit_i,
    input  logic ear_we_i,
    input  logic ear_bit_i,
    output logic wide_mode_o,
    output logic ear_bit_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_mode_o <= 1'b0;
            ear_bit_o   <= 1'b0;
        end else if (sw_rst_i) begin
            wide_mode_o <= 1'b0;
            ear_bit_o   <= 1'b0;
        end else begin
            if (exit_i)
                wide_mode_o <= 1'b0;
            else if (enter_i)
                wide_mode_o <= 1'b1;
            if (ear_we_i)
                ear_bit_o <= ear_bit_i;
        end
    end
endmodule

// File: rtl/fam_addr_assembler.sv
module fam_addr_assembler #(
    parameter int BYTE_W       = 8,
    parameter int NARROW_BYTES = 3,
    parameter int WIDE_BYTES   = 4,
    localparam int ADDR_W      = WIDE_BYTES * BYTE_W,
    localparam int NARROW_W    = NARROW_BYTES * BYTE_W,
    localparam int IDX_W       = $clog2(WIDE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              wide_i,
    input  logic              ear_bit_i,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] shift_q, shift_d;
    logic [IDX_W-1:0]  idx_q, need;

    assign need    = wide_i ? IDX_W'(WIDE_BYTES) : IDX_W'(NARROW_BYTES);
    assign shift_d = {shift_q[ADDR_W-BYTE_W-1:0], byte_i};
    assign last_o  = byte_vld_i && (idx_q == need - 1'b1);

    always_comb begin
        if (wide_i)
            addr_o = shift_d;
        else
            addr_o = {{(ADDR_W-NARROW_W-1){1'b0}}, ear_bit_i, shift_d[NARROW_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (start_i) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (byte_vld_i) begin
            shift_q <= shift_d;
            idx_q   <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/flash_addr_mode_ctrl.sv
module flash_addr_mode_ctrl
    import flash_am_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int NARROW_BYTES = 3,
    parameter int WIDE_BYTES   = 4,
    localparam int ADDR_W      = WIDE_BYTES * BYTE_W,
    localparam int CNT_W       = $clog2(WIDE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              op_vld_i,
    input  logic [7:0]        op_code_i,
    input  logic              wel_i,
    input  logic              sbyte_vld_i,
    input  logic [BYTE_W-1:0] sbyte_i,
    output logic [CNT_W-1:0]  addr_bytes_o,
    output logic              addr_bytes_vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic              wel_clr_o,
    output logic [7:0]        cfg_o,
    output logic [7:0]        ear_o
);
    fsm_state_e        state_q, state_d;
    op_class_e         op_cls;
    logic              wide_mode, ear_bit;
    logic              wide_cmd_q;
    logic              enter_w, exit_w, ear_we, asm_byte_vld, asm_last;
    logic [CNT_W-1:0]  cnt_d;
    logic [ADDR_W-1:0] asm_addr;

    fam_op_decoder u_dec (
        .op_code_i (op_code_i),
        .op_cls_o  (op_cls)
    );

    assign enter_w      = op_vld_i && (op_cls == OPC_ENTER4B);
    assign exit_w       = op_vld_i && (op_cls == OPC_EXIT4B);
    assign ear_we       = !op_vld_i && sbyte_vld_i && (state_q == ST_EARDATA);
    assign asm_byte_vld = !op_vld_i && sbyte_vld_i && (state_q == ST_ADDR);

    fam_mode_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst_i    (sw_rst_i),
        .enter_i     (enter_w),
        .exit_i      (exit_w),
        .ear_we_i    (ear_we),
        .ear_bit_i   (sbyte_i[0]),
        .wide_mode_o (wide_mode),
        .ear_bit_o   (ear_bit)
    );

    fam_addr_assembler #(
        .BYTE_W       (BYTE_W),
        .NARROW_BYTES (NARROW_BYTES),
        .WIDE_BYTES   (WIDE_BYTES)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (op_vld_i),
        .byte_vld_i (asm_byte_vld),
        .byte_i     (sbyte_i),
        .wide_i     (wide_cmd_q),
        .ear_bit_i  (ear_bit),
        .last_o     (asm_last),
        .addr_o     (asm_addr)
    );

    always_comb begin
        case (op_cls)
            OPC_WIDE:   cnt_d = CNT_W'(WIDE_BYTES);
            OPC_LEGACY: cnt_d = wide_mode ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);
            default:    cnt_d = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (op_vld_i) begin
            case (op_cls)
                OPC_WIDE, OPC_LEGACY: state_d = ST_ADDR;
                OPC_EARWR:            state_d = wel_i ? ST_EARDATA : ST_IDLE;
                default:              state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ADDR:    if (asm_last) state_d = ST_IDLE;
                ST_EARDATA: if (sbyte_vld_i) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (sw_rst_i)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_bytes_o     <= '0;
            addr_bytes_vld_o <= 1'b0;
            addr_o           <= '0;
            addr_vld_o       <= 1'b0;
            wel_clr_o        <= 1'b0;
            wide_cmd_q       <= 1'b0;
        end else if (sw_rst_i) begin
            addr_bytes_o     <= '0;
            addr_bytes_vld_o <= 1'b0;
            addr_o           <= '0;
            addr_vld_o       <= 1'b0;
            wel_clr_o        <= 1'b0;
            wide_cmd_q       <= 1'b0;
        end else begin
            addr_bytes_vld_o <= op_vld_i;
            addr_vld_o       <= asm_last;
            wel_clr_o        <= ear_we;
            if (op_vld_i) begin
                addr_bytes_o <= cnt_d;
                wide_cmd_q   <= (cnt_d == CNT_W'(WIDE_BYTES));
            end
            if (asm_last)
                addr_o <= asm_addr;
        end
    end

    assign cfg_o = {2'b00, wide_mode, 5'b00000};
    assign ear_o = {7'b0000000, ear_bit};

endmodule

// File: rtl/fam_addr_mode_chk.sv
module fam_addr_mode_chk #(
    parameter int BYTE_W       = 8,
    parameter int NARROW_BYTES = 3,
    parameter int WIDE_BYTES   = 4,
    localparam int ADDR_W      = WIDE_BYTES * BYTE_W,
    localparam int NARROW_W    = NARROW_BYTES * BYTE_W,
    localparam int CNT_W       = $clog2(WIDE_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst_i,
    input logic              op_vld_i,
    input logic [7:0]        op_code_i,
    input logic [CNT_W-1:0]  addr_bytes_o,
    input logic              addr_bytes_vld_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_vld_o,
    input logic              wel_clr_o,
    input logic [7:0]        cfg_o,
    input logic [7:0]        ear_o
);
    AST_ENTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && op_code_i == 8'hB7 && !sw_rst_i |=> cfg_o[5]); // R1

    AST_EXIT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && op_code_i == 8'hE9 && !sw_rst_i |=> !cfg_o[5]); // R1

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (cfg_o == 8'h00) && (ear_o == 8'h00)); // R2

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o && addr_bytes_o == CNT_W'(NARROW_BYTES)
        |-> (addr_o >> (NARROW_W + 1)) == '0); // R4

    AST_FIXED_WIDE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && !sw_rst_i &&
        (op_code_i inside {8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC,
                           8'h12, 8'h3E, 8'h21, 8'hDC, 8'h5C})
        |=> addr_bytes_o == CNT_W'(WIDE_BYTES)); // R6

    AST_EAR_CHANGE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ear_o != $past(ear_o)) && !$past(sw_rst_i) |-> wel_clr_o); // R9

    AST_COUNT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld_i && !sw_rst_i |=> addr_bytes_vld_o); // R11
endmodule

bind flash_addr_mode_ctrl fam_addr_mode_chk #(
    .BYTE_W       (BYTE_W),
    .NARROW_BYTES (NARROW_BYTES),
    .WIDE_BYTES   (WIDE_BYTES)
) u_fam_chk (.*);

// File: tb/test_flash_addr_mode_ctrl.sv
module test_flash_addr_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst_i = 1'b0;
    logic        op_vld_i = 1'b0;
    logic [7:0]  op_code_i = 8'h00;
    logic        wel_i = 1'b0;
    logic        sbyte_vld_i = 1'b0;
    logic [7:0]  sbyte_i = 8'h00;
    logic [2:0]  addr_bytes_o;
    logic        addr_bytes_vld_o;
    logic [31:0] addr_o;
    logic        addr_vld_o;
    logic        wel_clr_o;
    logic [7:0]  cfg_o;
    logic [7:0]  ear_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flash_addr_mode_ctrl i_flash_addr_mode_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_rst_i         (sw_rst_i),
        .op_vld_i         (op_vld_i),
        .op_code_i        (op_code_i),
        .wel_i            (wel_i),
        .sbyte_vld_i      (sbyte_vld_i),
        .sbyte_i          (sbyte_i),
        .addr_bytes_o     (addr_bytes_o),
        .addr_bytes_vld_o (addr_bytes_vld_o),
        .addr_o           (addr_o),
        .addr_vld_o       (addr_vld_o),
        .wel_clr_o        (wel_clr_o),
        .cfg_o            (cfg_o),
        .ear_o            (ear_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] op);
        @(negedge clk);
        op_vld_i  = 1'b1;
        op_code_i = op;
        @(negedge clk);
        op_vld_i  = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        sbyte_vld_i = 1'b1;
        sbyte_i     = b;
        @(negedge clk);
        sbyte_vld_i = 1'b0;
    endtask

    task automatic run_addr(input string req, input logic [7:0] op, input int n,
                            input logic [31:0] bytes, input logic [31:0] exp_addr);
        strobe(op);
        check({req, " count valid"}, {31'd0, addr_bytes_vld_o}, 32'd1);
        check({req, " count"}, {29'd0, addr_bytes_o}, n);
        for (int i = n - 1; i >= 0; i--) begin
            send_byte(bytes[i*8 +: 8]);
            if (i != 0)
                check({req, " no early address"}, {31'd0, addr_vld_o}, 32'd0);
        end
        check({req, " address valid"}, {31'd0, addr_vld_o}, 32'd1);
        check({req, " address"}, addr_o, exp_addr);
    endtask

    task automatic t_reset;
        check("R2 reset cfg", {24'd0, cfg_o}, 32'h0);
        check("R2 reset ear", {24'd0, ear_o}, 32'h0);
        check("R11 reset no count pulse", {31'd0, addr_bytes_vld_o}, 32'd0);
    endtask

    task automatic t_legacy_narrow;
        run_addr("R7 R4 R11 narrow read", 8'h03, 3, 32'h00123456, 32'h00123456);
        run_addr("R7 R4 narrow program", 8'h02, 3, 32'h00FFFFFF, 32'h00FFFFFF);
    endtask

    task automatic t_ear_write_denied;
        wel_i = 1'b0;
        strobe(8'hC5);
        check("R9 denied write count", {29'd0, addr_bytes_o}, 32'd0);
        send_byte(8'h01);
        check("R9 no latch clear", {31'd0, wel_clr_o}, 32'd0);
        check("R9 ear unchanged", {24'd0, ear_o}, 32'h0);
        run_addr("R9 bit24 still low", 8'h0B, 3, 32'h00ABCDEF, 32'h00ABCDEF);
    endtask

    task automatic t_ear_write;
        wel_i = 1'b1;
        strobe(8'hC5);
        wel_i = 1'b0;
        send_byte(8'hFF);
        check("R10 latch clear pulse", {31'd0, wel_clr_o}, 32'd1);
        check("R10 R5 ear readback", {24'd0, ear_o}, 32'h01);
        @(negedge clk);
        check("R10 pulse single cycle", {31'd0, wel_clr_o}, 32'd0);
        run_addr("R4 narrow with ext bit", 8'h03, 3, 32'h00ABCDEF, 32'h01ABCDEF);
        strobe(8'hC8);
        check("R5 readback opcode count", {29'd0, addr_bytes_o}, 32'd0);
    endtask

    task automatic t_wide_mode;
        wel_i = 1'b0;
        strobe(8'hB7);
        check("R1 enter without latch", {24'd0, cfg_o}, 32'h20);
        check("R3 cfg other bits", {24'd0, cfg_o & 8'hDF}, 32'h0);
        run_addr("R7 R8 wide legacy read", 8'h03, 4, 32'h89ABCDEF, 32'h89ABCDEF);
        strobe(8'hE9);
        check("R1 R3 exit without latch", {24'd0, cfg_o}, 32'h00);
        strobe(8'h0B);
        check("R7 narrow after exit", {29'd0, addr_bytes_o}, 32'd3);
    endtask

    task automatic t_fixed_opcodes;
        logic [7:0] ops [11] = '{8'h13, 8'h0C, 8'h3C, 8'hBC, 8'h6C, 8'hEC,
                                8'h12, 8'h3E, 8'h21, 8'hDC, 8'h5C};
        for (int i = 0; i < 11; i++) begin
            strobe(ops[i]);
            check("R6 fixed opcode in narrow mode", {29'd0, addr_bytes_o}, 32'd4);
        end
        run_addr("R8 R6 fixed ignores ext bit", 8'h13, 4, 32'hFEDCBA98, 32'hFEDCBA98);
        strobe(8'hB7);
        strobe(8'h5C);
        check("R6 fixed opcode in wide mode", {29'd0, addr_bytes_o}, 32'd4);
        strobe(8'hE9);
    endtask

    task automatic t_no_addr_ops;
        strobe(8'h06);
        check("R7 no-address opcode 06", {29'd0, addr_bytes_o}, 32'd0);
        strobe(8'h05);
        check("R7 no-address opcode 05", {29'd0, addr_bytes_o}, 32'd0);
        strobe(8'hB7);
        check("R7 mode opcode count", {29'd0, addr_bytes_o}, 32'd0);
        strobe(8'hE9);
    endtask

    task automatic t_abort;
        strobe(8'h03);
        send_byte(8'h11);
        send_byte(8'h22);
        check("R12 partial no address", {31'd0, addr_vld_o}, 32'd0);
        run_addr("R12 restart with wide opcode", 8'h0C, 4, 32'h33445566, 32'h33445566);
    endtask

    task automatic t_soft_reset;
        strobe(8'hB7);
        check("R1 set before soft reset", {24'd0, cfg_o}, 32'h20);
        @(negedge clk);
        sw_rst_i = 1'b1;
        @(negedge clk);
        sw_rst_i = 1'b0;
        check("R2 soft reset mode", {24'd0, cfg_o}, 32'h00);
        check("R2 soft reset ear", {24'd0, ear_o}, 32'h00);
        run_addr("R2 narrow after soft reset", 8'h03, 3, 32'h00010203, 32'h00010203);
    endtask

    task automatic t_hw_reset;
        strobe(8'hB7);
        wel_i = 1'b1;
        strobe(8'hC5);
        wel_i = 1'b0;
        send_byte(8'h01);
        check("R10 ear set before hw reset", {24'd0, ear_o}, 32'h01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 hw reset mode", {24'd0, cfg_o}, 32'h00);
        check("R2 hw reset ear", {24'd0, ear_o}, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_narrow();
        t_ear_write_denied();
        t_ear_write();
        t_wide_mode();
        t_fixed_opcodes();
        t_no_addr_ops();
        t_abort();
        t_soft_reset();
        t_hw_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule